// File: doc/BRIEF.md
# Tag Signature Hash Generator

This block turns the tag bits of a request address, the bits that sit just above the set index, into a short signature. A compressed cache keeps several signatures in one tag entry, so each one must be small. The block folds the tag with XOR into one signature-wide value. It splits that value into a high part and a low part, and it passes each part through its own small remap table. The two table outputs, joined together, form the signature.

The remap tables are filled with pseudo-random values after every reset. A 16-bit LFSR supplies these values and takes its starting state from a seed input. Filling takes one cycle per table entry, and a ready output stays low until it is done. Any request made before ready is ignored.

The high table is never allowed to hold the all-ones nibble. Because of this, every signature whose top four bits are all ones can never be produced. Two of those codes are set aside for the tag array: 9'h1FF marks an empty sub-slot, and 9'h1FE marks a superblock.

Top module: `tag_sig_hash`

## Requirements
- R1: The 27-bit tag is cut into three 9-bit segments (bits 8:0, 17:9 and 26:18), and the fold value is the XOR of the three. Tags with the same fold always give the same signature.
- R2: The signature is {HT[fold[8:5]], LT[fold[4:0]]}. HT is a 16-entry table of 4-bit values, and it gives signature bits 8:5. LT is a 32-entry table of 5-bit values, and it gives signature bits 4:0.
- R3: No HT entry equals 4'b1111. So no signature has its top nibble all ones, and the reserved codes 9'h1FF (empty sub-slot) and 9'h1FE (superblock marker) are never produced.
- R4: ready is low during reset. It goes high exactly at the 48th rising clock edge after reset is released, and then stays high until the next reset.
- R5: A request made while ready is low is ignored. No sig_valid pulse follows, and sig keeps its reset value of zero.
- R6: sig_valid is high in the cycle right after an accepted request (req_valid high while ready is high), and low otherwise. sig changes only on accepted requests and holds between them. Back-to-back requests give one result per cycle.
- R7: Table contents come from a Galois LFSR that shifts right. The next state is (s>>1) XOR (s[0] ? 16'hB400 : 0).
  - The LFSR loads `seed` during reset; a seed of zero is replaced by 16'h0001.
  - Fill step k (k = 0..47) uses the state before that step's shift.
  - Steps 0..15 write HT[k] with the low 4 state bits. A draw of 4'b1111 is written as 4'b1110.
  - Steps 16..47 write LT[k-16] with the low 5 state bits.
- R8: The tables do not change after filling. A new reset rebuilds them from the seed present during that reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| seed | input | 16 | LFSR starting state, sampled while in reset |
| req_valid | input | 1 | Request strobe |
| req_tag | input | 27 | Tag bits of the request address |
| ready | output | 1 | Tables filled; requests are accepted |
| sig_valid | output | 1 | sig holds a fresh result this cycle |
| sig | output | 9 | Signature of the last accepted request |

## Verification
The bench rebuilds both tables from the seed with its own LFSR model and checks every signature against that model. This catches a design that taps the wrong bits, swaps the high and low parts, or misorders the fill. It also catches a design that skips the replacement of the 1111 draw, because a full sweep of all 512 fold values would then show a reserved code. Other tests count the exact edge where ready rises, which exposes an off-by-one fill counter. They also send requests during the fill, which shows up a design that answers before its tables are complete. Reseeding, the zero seed, and tags with permuted segments cover the rebuild path and the fold.

// File: rtl/tag_sig_hash.sv
module tag_sig_hash #(
  parameter int TAG_W     = 27,
  parameter int SIG_W     = 9,
  parameter int HI_W      = 4,
  parameter int LFSR_W    = 16,
  parameter logic [15:0] LFSR_MASK = 16'hB400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] seed,
  input  logic              req_valid,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              ready,
  output logic              sig_valid,
  output logic [SIG_W-1:0]  sig
);
  localparam int LO_W   = SIG_W - HI_W;
  localparam int SEGS   = TAG_W / SIG_W;
  localparam int HI_N   = 1 << HI_W;
  localparam int LO_N   = 1 << LO_W;
  localparam int FILL_N = HI_N + LO_N;
  localparam int CNT_W  = $clog2(FILL_N + 1);
  localparam logic [SIG_W-1:0] SIG_EMPTY = '1;
  localparam logic [SIG_W-1:0] SIG_SUPER = {{HI_W{1'b1}}, {(LO_W-1){1'b1}}, 1'b0};

  logic [HI_W-1:0]   hi_tab [HI_N];
  logic [LO_W-1:0]   lo_tab [LO_N];
  logic [LFSR_W-1:0] lfsr, lfsr_nxt;
  logic [CNT_W-1:0]  fill_cnt, lo_off;
  logic [SIG_W-1:0]  fold;
  logic [HI_W-1:0]   hi_draw;
  logic [LO_W-1:0]   lo_draw;
  logic              accept;

  always_comb begin
    fold = '0;
    for (int s = 0; s < SEGS; s++) fold = fold ^ req_tag[s*SIG_W +: SIG_W];
  end

  assign lfsr_nxt = (lfsr >> 1) ^ (lfsr[0] ? LFSR_MASK[LFSR_W-1:0] : '0);
  assign hi_draw  = (lfsr[HI_W-1:0] == '1) ? {{(HI_W-1){1'b1}}, 1'b0} : lfsr[HI_W-1:0];
  assign lo_draw  = lfsr[LO_W-1:0];
  assign lo_off   = fill_cnt - CNT_W'(HI_N);
  assign ready    = (fill_cnt == CNT_W'(FILL_N));
  assign accept   = req_valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr      <= (seed == '0) ? LFSR_W'(1) : seed;
      fill_cnt  <= '0;
      sig_valid <= 1'b0;
      sig       <= '0;
    end else begin
      sig_valid <= accept;
      if (accept) sig <= {hi_tab[fold[SIG_W-1 -: HI_W]], lo_tab[fold[LO_W-1:0]]};
      if (!ready) begin
        lfsr     <= lfsr_nxt;
        fill_cnt <= fill_cnt + 1'b1;
        if (fill_cnt < CNT_W'(HI_N)) hi_tab[fill_cnt[HI_W-1:0]] <= hi_draw;
        else                         lo_tab[lo_off[LO_W-1:0]]   <= lo_draw;
      end
    end
  end

  AST_SIG_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |-> (sig[SIG_W-1 -: HI_W] != '1 && sig != SIG_EMPTY && sig != SIG_SUPER)); // R3
  AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready); // R4
  AST_READY_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(fill_cnt) == CNT_W'(FILL_N - 1)); // R4
  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    sig_valid |-> $past(req_valid && ready)); // R6
  AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R7
endmodule

// File: tb/tag_sig_hash_test.sv
module tag_sig_hash_test;
  localparam int CLK_T = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] seed = 16'h1234;
  logic        req_valid = 1'b0;
  logic [26:0] req_tag = '0;
  logic        ready, sig_valid;
  logic [8:0]  sig;

  int n_run = 0, n_fail = 0, cyc = 0;
  logic [3:0] m_hi [16];
  logic [4:0] m_lo [32];

  tag_sig_hash uut (.clk(clk), .rst_n(rst_n), .seed(seed), .req_valid(req_valid),
                    .req_tag(req_tag), .ready(ready), .sig_valid(sig_valid), .sig(sig));

  always #(CLK_T/2) clk = ~clk;

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog: actual cycles=%0d expected done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic build_model(input logic [15:0] sd);
    logic [15:0] s = (sd == 0) ? 16'h0001 : sd;
    for (int k = 0; k < 48; k++) begin
      if (k < 16) m_hi[k] = (s[3:0] == 4'hF) ? 4'hE : s[3:0];
      else        m_lo[k-16] = s[4:0];
      s = (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0);
    end
  endtask

  function automatic logic [8:0] exp_sig(input logic [26:0] t);
    logic [8:0] f = t[8:0] ^ t[17:9] ^ t[26:18];
    return {m_hi[f[8:5]], m_lo[f[4:0]]};
  endfunction

  task automatic do_reset(input logic [15:0] sd);
    @(negedge clk);
    rst_n = 1'b0; seed = sd; req_valid = 1'b0;
    repeat (3) @(negedge clk);
    build_model(sd);
  endtask

  task automatic fill_and_ready();
    rst_n = 1'b1;
    req_valid = 1'b1; req_tag = 27'h5A5A5A5;
    for (int i = 1; i <= 48; i++) begin
      @(negedge clk);
      if (i == 10) req_valid = 1'b0;
      if (i <= 11) begin
        chk("R5 sig_valid during fill", sig_valid, 0);
        chk("R5 sig during fill", sig, 0);
      end
      if (i == 47) chk("R4 ready before 48th edge", ready, 0);
      if (i == 48) chk("R4 ready at 48th edge", ready, 1);
    end
    @(negedge clk);
    chk("R4 ready stays high", ready, 1);
  endtask

  task automatic one_req(input string req, input logic [26:0] t);
    logic [8:0] e = exp_sig(t);
    req_valid = 1'b1; req_tag = t;
    @(negedge clk);
    req_valid = 1'b0;
    chk({req, " sig_valid"}, sig_valid, 1);
    chk({req, " sig"}, sig, e);
    @(negedge clk);
    chk("R6 sig_valid drops", sig_valid, 0);
    chk("R6 sig held", sig, e);
  endtask

  task automatic t_reset_state();
    do_reset(16'h1234);
    chk("R4 ready in reset", ready, 0);
    chk("R6 sig_valid in reset", sig_valid, 0);
    chk("R5 sig in reset", sig, 0);
    fill_and_ready();
  endtask

  task automatic t_patterns();
    one_req("R2 zero tag", 27'h0);
    one_req("R2 all ones", 27'h7FFFFFF);
    one_req("R7 pattern a", 27'h1234567);
    one_req("R7 pattern b", 27'h0ABCDEF);
    one_req("R2 single bit", 27'h0000100);
  endtask

  task automatic t_fold_alias();
    logic [26:0] a = {9'h0C3, 9'h11F, 9'h02A};
    logic [26:0] b = {9'h02A, 9'h0C3, 9'h11F};
    logic [26:0] c = {9'h000, 9'h000, 9'h0C3 ^ 9'h11F ^ 9'h02A};
    logic [8:0] sa;
    one_req("R1 alias a", a);
    sa = sig;
    one_req("R1 alias b", b);
    chk("R1 permuted segments match", sig, sa);
    one_req("R1 alias c", c);
    chk("R1 folded tag match", sig, sa);
  endtask

  task automatic t_back_to_back();
    logic [26:0] t;
    req_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      t = 27'(i * 32'h0123457 + 32'h3F);
      req_tag = t;
      @(negedge clk);
      chk("R6 back-to-back valid", sig_valid, 1);
      chk("R6 back-to-back sig", sig, exp_sig(t));
    end
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reserved_sweep();
    int bad = 0;
    req_valid = 1'b1;
    for (int f = 0; f < 512; f++) begin
      req_tag = 27'(f);
      @(negedge clk);
      if (sig[8:5] == 4'hF || sig != exp_sig(27'(f))) bad++;
    end
    req_valid = 1'b0;
    chk("R3 no reserved code over all folds", bad, 0);
    for (int k = 0; k < 16; k++) if (m_hi[k] == 4'hF) bad++;
    chk("R3 model table free of 1111", bad, 0);
  endtask

  task automatic t_reseed(input logic [15:0] sd, input string req);
    do_reset(sd);
    fill_and_ready();
    one_req(req, 27'h1234567);
    one_req(req, 27'h7654321);
    one_req(req, 27'h00001FF);
  endtask

  initial begin
    t_reset_state();
    t_patterns();
    t_fold_alias();
    t_back_to_back();
    t_reserved_sweep();
    t_reseed(16'hFFFF, "R8 reseed ffff");
    t_reserved_sweep();
    t_reseed(16'h0000, "R7 zero seed");
    t_reseed(16'h1234, "R8 same seed again");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule